// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers single-cycle event pulses from a data-link controller and presents them to a host processor through a small register port. A primary status register carries five direct event bits and three summary bits. Each summary bit stands for one secondary register of eight event bits: a D-channel group and two B-channel groups. A mask register selects which primary bits may be seen and which may raise the single interrupt line.

A masked event is not thrown away. It stays latched, reads as zero, and shows up, with an interrupt, as soon as software clears its mask bit. Reading the primary register clears its visible direct bits. The summary bits ignore that read and follow their own rule. The D summary bit follows the contents of the D register. Each B summary bit is a sticky flag that only a read of its own secondary register clears. An event that arrives in the same cycle as a clearing read always survives that read.

The register offsets are parameters. By default the primary status register is at 0, the mask at 1, the D group at 2, B1 at 3 and B2 at 4. Reads are combinational: `reg_rdata` carries the addressed register while `reg_rd` is high, and a read-to-clear takes effect at the clock edge that ends the read cycle.

Top module: `intagg_top`

## Requirements
- R1: After reset the mask register reads 0xFF, the primary status register and all three secondary registers read 0x00, and `irq_o` is low.
- R2: A write at the mask offset loads `reg_wdata` into the mask, and a read at that offset returns it. Writes at the primary status offset and at the secondary offsets change nothing.
- R3: A pulse on `evt_direct[4:0]` latches into primary bits 7 to 3 in the same order: bit 4 of `evt_direct` goes to status bit 7, and bit 0 goes to status bit 3. A primary bit reads as its latched value AND NOT its mask bit.
- R4: A direct event whose mask bit is 1 reads as 0 and does not raise `irq_o`. Once that mask bit is written to 0, the event reads as 1 and raises `irq_o`.
- R5: A read of the primary register clears the direct bits that were visible. Direct bits that were masked stay pending, and summary bits 2 to 0 are not affected.
- R6: The D secondary register latches `evt_d`. Bit 4 is reserved: it ignores its event and always reads 0. A read of the D register clears it.
- R7: Primary bit 2 (D summary) is 1 exactly while the D secondary register holds any set bit.
- R8: Primary bit 1 (B1 summary) and bit 0 (B2 summary) are set by any event in their group. Each clears only when the host reads its own secondary register, which also clears that register.
- R9: A mask bit of 1 at position 2, 1 or 0 hides the whole matching group from the primary register and from `irq_o`. The secondary register itself still latches and reads its events.
- R10: An event that arrives in the same cycle as a clearing read of its register is latched after that read.
- R11: `irq_o` is high exactly when the primary register would read non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W (3) | Register offset |
| reg_rd | input | 1 | Read strobe; read-to-clear acts at the edge ending the cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when no read |
| evt_direct | input | 5 | Direct event pulses for primary bits 7..3 |
| evt_d | input | 8 | D group event pulses |
| evt_b1 | input | 8 | B1 group event pulses |
| evt_b2 | input | 8 | B2 group event pulses |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench targets an event that collides with a clearing read. A design that cleared after setting would lose that event, and the next read would show zero. It also reads the primary register while a direct bit is masked. A design that cleared every latched bit would drop the pending event, so it would never appear after the mask is lifted. The bench reads the primary register to check that the summary bits survive, and reads the reserved D bit. A summary bit that cleared on the primary read, or a reserved bit that latched, would return a wrong value. A long run of random reads, writes and events is also compared, every cycle, against a behavioural model of the registers.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    localparam int REG_W    = 8;
    localparam int DIRECT_N = 5;
    localparam int GROUP_N  = 3;

    // group index: 0 = D, 1 = B1, 2 = B2
    localparam int GRP_D  = 0;
    localparam int GRP_B1 = 1;
    localparam int GRP_B2 = 2;

    // reserved bit inside the D group
    localparam logic [REG_W-1:0] D_RSVD = 8'h10;

    // default register offsets
    localparam int OFS_PRIM_DEF = 0;
    localparam int OFS_MASK_DEF = 1;
    localparam int OFS_D_DEF    = 2;
    localparam int OFS_B1_DEF   = 3;
    localparam int OFS_B2_DEF   = 4;

    typedef enum logic [0:0] {
        SUM_FROM_BITS = 1'b0,
        SUM_STICKY    = 1'b1
    } sum_mode_e;

    // primary status layout: direct events on top, summaries below
    typedef struct packed {
        logic [DIRECT_N-1:0] direct;
        logic                d_sum;
        logic                b1_sum;
        logic                b2_sum;
    } prim_stat_t;

    function automatic logic [REG_W-1:0] visible(input prim_stat_t s,
                                                 input logic [REG_W-1:0] m);
        return s & ~m;
    endfunction

    function automatic logic [REG_W-1:0] rsvd_of(input int grp);
        return (grp == GRP_D) ? D_RSVD : '0;
    endfunction

    function automatic sum_mode_e mode_of(input int grp);
        return (grp == GRP_D) ? SUM_FROM_BITS : SUM_STICKY;
    endfunction

endpackage

// File: rtl/intagg_ext_group.sv
module intagg_ext_group
    import intagg_pkg::*;
#(
    parameter int               W    = 8,
    parameter logic [W-1:0]     RSVD = '0,
    parameter sum_mode_e        MODE = SUM_FROM_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    output logic [W-1:0] bits_o,
    output logic         sum_o
);

    logic [W-1:0] lat_q;
    logic [W-1:0] evt_ok;

    assign evt_ok = evt & ~RSVD;

    // clear first, then merge new events so none is lost
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else begin
            lat_q <= (rd_clr ? '0 : lat_q) | evt_ok;
        end
    end

    assign bits_o = lat_q;

    generate
        if (MODE == SUM_STICKY) begin : g_sticky
            logic sum_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sum_q <= 1'b0;
                end else begin
                    sum_q <= (rd_clr ? 1'b0 : sum_q) | (|evt_ok);
                end
            end
            assign sum_o = sum_q;
        end else begin : g_or
            assign sum_o = |lat_q;
        end
    endgenerate

endmodule

// File: rtl/intagg_prim.sv
module intagg_prim
    import intagg_pkg::*;
#(
    parameter int N = DIRECT_N,
    parameter int G = GROUP_N,
    localparam int W = N + G
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [G-1:0] sums,
    input  logic [W-1:0] mask,
    input  logic         rd_clr,
    output logic [N-1:0] direct_o,
    output logic [W-1:0] vis_o,
    output logic         irq_o
);

    logic [N-1:0] direct_q;
    logic [N-1:0] keep;
    prim_stat_t   stat;

    // masked bits survive a status read and stay pending
    assign keep = mask[W-1:G];

    always_ff @(posedge clk) begin
        if (rst) begin
            direct_q <= '0;
        end else begin
            direct_q <= (rd_clr ? (direct_q & keep) : direct_q) | evt;
        end
    end

    always_comb begin
        stat.direct = direct_q;
        stat.d_sum  = sums[G-1-GRP_D];
        stat.b1_sum = sums[G-1-GRP_B1];
        stat.b2_sum = sums[G-1-GRP_B2];
    end

    assign vis_o    = visible(stat, mask);
    assign irq_o    = |vis_o;
    assign direct_o = direct_q;

endmodule

// File: rtl/intagg_regif.sv
module intagg_regif
    import intagg_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int W        = REG_W,
    parameter int OFS_PRIM = OFS_PRIM_DEF,
    parameter int OFS_MASK = OFS_MASK_DEF,
    parameter int OFS_D    = OFS_D_DEF,
    parameter int OFS_B1   = OFS_B1_DEF,
    parameter int OFS_B2   = OFS_B2_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      vis,
    input  logic [W-1:0]      d_bits,
    input  logic [W-1:0]      b1_bits,
    input  logic [W-1:0]      b2_bits,
    output logic [W-1:0]      mask_o,
    output logic              rd_prim,
    output logic              rd_d,
    output logic              rd_b1,
    output logic              rd_b2,
    output logic [W-1:0]      rdata
);

    localparam int NREG = 5;
    localparam int SEL_PRIM = 0;
    localparam int SEL_MASK = 1;
    localparam int SEL_D    = 2;
    localparam int SEL_B1   = 3;
    localparam int SEL_B2   = 4;
    localparam int OFS_TAB [NREG] = '{OFS_PRIM, OFS_MASK, OFS_D, OFS_B1, OFS_B2};

    logic [NREG-1:0] hit;
    logic [W-1:0]    mask_q;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_dec
            assign hit[i] = (addr == ADDR_W'(OFS_TAB[i]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (wr && hit[SEL_MASK]) begin
            mask_q <= wdata;
        end
    end

    assign mask_o  = mask_q;
    assign rd_prim = rd && hit[SEL_PRIM];
    assign rd_d    = rd && hit[SEL_D];
    assign rd_b1   = rd && hit[SEL_B1];
    assign rd_b2   = rd && hit[SEL_B2];

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (hit[SEL_PRIM])      rdata = vis;
            else if (hit[SEL_MASK]) rdata = mask_q;
            else if (hit[SEL_D])    rdata = d_bits;
            else if (hit[SEL_B1])   rdata = b1_bits;
            else if (hit[SEL_B2])   rdata = b2_bits;
        end
    end

endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int OFS_PRIM = OFS_PRIM_DEF,
    parameter int OFS_MASK = OFS_MASK_DEF,
    parameter int OFS_D    = OFS_D_DEF,
    parameter int OFS_B1   = OFS_B1_DEF,
    parameter int OFS_B2   = OFS_B2_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [DIRECT_N-1:0] evt_direct,
    input  logic [REG_W-1:0]    evt_d,
    input  logic [REG_W-1:0]    evt_b1,
    input  logic [REG_W-1:0]    evt_b2,
    output logic                irq_o
);

    logic [REG_W-1:0]    grp_evt  [GROUP_N];
    logic [REG_W-1:0]    grp_bits [GROUP_N];
    logic [GROUP_N-1:0]  grp_clr;
    logic [GROUP_N-1:0]  grp_sum;
    logic [GROUP_N-1:0]  sums_w;
    logic [REG_W-1:0]    mask_w;
    logic [REG_W-1:0]    vis_w;
    logic [DIRECT_N-1:0] direct_w;
    logic                rd_prim;

    assign grp_evt[GRP_D]  = evt_d;
    assign grp_evt[GRP_B1] = evt_b1;
    assign grp_evt[GRP_B2] = evt_b2;

    generate
        for (genvar g = 0; g < GROUP_N; g++) begin : g_grp
            intagg_ext_group #(
                .W    (REG_W),
                .RSVD (rsvd_of(g)),
                .MODE (mode_of(g))
            ) u_grp (
                .clk    (clk),
                .rst    (rst),
                .evt    (grp_evt[g]),
                .rd_clr (grp_clr[g]),
                .bits_o (grp_bits[g]),
                .sum_o  (grp_sum[g])
            );
            assign sums_w[GROUP_N-1-g] = grp_sum[g];
        end
    endgenerate

    intagg_prim #(
        .N (DIRECT_N),
        .G (GROUP_N)
    ) u_prim (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_direct),
        .sums     (sums_w),
        .mask     (mask_w),
        .rd_clr   (rd_prim),
        .direct_o (direct_w),
        .vis_o    (vis_w),
        .irq_o    (irq_o)
    );

    intagg_regif #(
        .ADDR_W   (ADDR_W),
        .W        (REG_W),
        .OFS_PRIM (OFS_PRIM),
        .OFS_MASK (OFS_MASK),
        .OFS_D    (OFS_D),
        .OFS_B1   (OFS_B1),
        .OFS_B2   (OFS_B2)
    ) u_regif (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .rd      (reg_rd),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .vis     (vis_w),
        .d_bits  (grp_bits[GRP_D]),
        .b1_bits (grp_bits[GRP_B1]),
        .b2_bits (grp_bits[GRP_B2]),
        .mask_o  (mask_w),
        .rd_prim (rd_prim),
        .rd_d    (grp_clr[GRP_D]),
        .rd_b1   (grp_clr[GRP_B1]),
        .rd_b2   (grp_clr[GRP_B2]),
        .rdata   (reg_rdata)
    );

endmodule

// File: rtl/intagg_chk.sv
module intagg_chk #(
    parameter int ADDR_W   = 3,
    parameter int OFS_PRIM = 0,
    parameter int OFS_MASK = 1,
    parameter int OFS_D    = 2,
    parameter int OFS_B1   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [7:0]        reg_rdata,
    input logic [4:0]        evt_direct,
    input logic [7:0]        evt_b1,
    input logic              irq_o,
    input logic [7:0]        mask_q,
    input logic [4:0]        direct_q,
    input logic [7:0]        d_bits,
    input logic              b1_sum
);

    logic rd_prim_c;
    assign rd_prim_c = reg_rd && (reg_addr == ADDR_W'(OFS_PRIM));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == ADDR_W'(OFS_MASK)) |=> $stable(mask_q));

    // R11
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        rd_prim_c |-> (irq_o == (reg_rdata != 8'h00)));

    // R5
    prim_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_prim_c && !reg_wr && evt_direct == 5'b0) |=> ((direct_q & ~mask_q[7:3]) == 5'b0));

    // R10
    evt_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_direct != 5'b0) |=> ((direct_q & $past(evt_direct)) == $past(evt_direct)));

    // R6
    d_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_W'(OFS_D)) |-> !reg_rdata[4]);

    // R7
    d_sum_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_prim_c && d_bits == 8'h00) |-> !reg_rdata[2]);

    // R8
    b1_sum_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_W'(OFS_B1) && evt_b1 == 8'h00) |=> !b1_sum);

    // R9
    grp_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_prim_c && mask_q[2]) |-> !reg_rdata[2]);

endmodule

bind intagg_top intagg_chk #(
    .ADDR_W   (ADDR_W),
    .OFS_PRIM (OFS_PRIM),
    .OFS_MASK (OFS_MASK),
    .OFS_D    (OFS_D),
    .OFS_B1   (OFS_B1)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .evt_direct (evt_direct),
    .evt_b1     (evt_b1),
    .irq_o      (irq_o),
    .mask_q     (mask_w),
    .direct_q   (direct_w),
    .d_bits     (grp_bits[0]),
    .b1_sum     (grp_sum[1])
);

// File: tb/intagg_top_tb_top.sv
module intagg_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] evt_direct = '0;
    logic [7:0] evt_d = '0;
    logic [7:0] evt_b1 = '0;
    logic [7:0] evt_b2 = '0;
    logic       irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // behavioural register model
    bit [4:0] m_dir;
    bit [7:0] m_d, m_b1, m_b2, m_mask;
    logic [7:0] last_rdata;
    logic       last_irq;

    always #4 clk = ~clk;

    intagg_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_direct (evt_direct),
        .evt_d      (evt_d),
        .evt_b1     (evt_b1),
        .evt_b2     (evt_b2),
        .irq_o      (irq_o)
    );

    function automatic bit [7:0] m_vis();
        bit [7:0] raw;
        raw = {m_dir, (m_d != 0), (m_b1 != 0), (m_b2 != 0)};
        return raw & ~m_mask;
    endfunction

    function automatic bit [7:0] m_read(input bit [2:0] a);
        case (a)
            3'd0: return m_vis();
            3'd1: return m_mask;
            3'd2: return m_d;
            3'd3: return m_b1;
            3'd4: return m_b2;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input bit [2:0] a);
        case (a)
            3'd0: return "R3";
            3'd1: return "R2";
            3'd2: return "R6";
            3'd3, 3'd4: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one bus cycle, entered and left at a falling edge
    task automatic cycle(input bit r, input bit w, input bit [2:0] a, input bit [7:0] d,
                         input bit [4:0] ed, input bit [7:0] dd, input bit [7:0] b1, input bit [7:0] b2);
        bit [7:0] exp_rd;
        bit       exp_irq;
        reg_rd = r; reg_wr = w; reg_addr = a; reg_wdata = d;
        evt_direct = ed; evt_d = dd; evt_b1 = b1; evt_b2 = b2;
        #2;
        exp_rd  = m_read(a);
        exp_irq = (m_vis() != 0);
        last_rdata = reg_rdata;
        last_irq   = irq_o;
        if (r) chk(reg_rdata === exp_rd, tag_of(a), reg_rdata, exp_rd);
        chk(irq_o === exp_irq, "R11", {7'b0, irq_o}, {7'b0, exp_irq});
        @(posedge clk);
        if (r && a == 3'd0) m_dir = m_dir & m_mask[7:3];
        m_dir = m_dir | ed;
        if (r && a == 3'd2) m_d = 0;
        m_d = m_d | (dd & 8'hEF);
        if (r && a == 3'd3) m_b1 = 0;
        m_b1 = m_b1 | b1;
        if (r && a == 3'd4) m_b2 = 0;
        m_b2 = m_b2 | b2;
        if (w && a == 3'd1) m_mask = d;
        @(negedge clk);
        reg_rd = 0; reg_wr = 0;
        evt_direct = 0; evt_d = 0; evt_b1 = 0; evt_b2 = 0;
    endtask

    task automatic rd(input bit [2:0] a, input bit [7:0] exp, input string tag);
        cycle(1, 0, a, 0, 0, 0, 0, 0);
        chk(last_rdata === exp, tag, last_rdata, exp);
    endtask

    task automatic rd_ev(input bit [2:0] a, input bit [7:0] exp, input string tag,
                         input bit [4:0] ed, input bit [7:0] dd, input bit [7:0] b1);
        cycle(1, 0, a, 0, ed, dd, b1, 0);
        chk(last_rdata === exp, tag, last_rdata, exp);
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        cycle(0, 1, a, d, 0, 0, 0, 0);
    endtask

    task automatic ev(input bit [4:0] ed, input bit [7:0] dd, input bit [7:0] b1, input bit [7:0] b2);
        cycle(0, 0, 0, 0, ed, dd, b1, b2);
    endtask

    task automatic irq_is(input bit exp, input string tag);
        cycle(0, 0, 0, 0, 0, 0, 0, 0);
        chk(last_irq === exp, tag, {7'b0, last_irq}, {7'b0, exp});
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        m_dir = 0; m_d = 0; m_b1 = 0; m_b2 = 0; m_mask = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        irq_is(0, "R1");
        rd(1, 8'hFF, "R1");
        rd(0, 8'h00, "R1");
        rd(2, 8'h00, "R1");
        rd(4, 8'h00, "R1");

        // R2 mask write, ignored writes elsewhere
        wr(1, 8'h00);
        rd(1, 8'h00, "R2");
        wr(0, 8'hFF);
        wr(2, 8'hFF);
        wr(3, 8'hFF);
        rd(0, 8'h00, "R2");
        rd(2, 8'h00, "R2");
        rd(3, 8'h00, "R2");

        // R3 direct bit positions, R11 interrupt
        ev(5'b10101, 0, 0, 0);
        irq_is(1, "R11");
        rd(0, 8'hA8, "R3");
        rd(0, 8'h00, "R5");
        irq_is(0, "R11");

        // R4 masked pending, R5 read keeps masked bit
        wr(1, 8'h80);
        ev(5'b10000, 0, 0, 0);
        irq_is(0, "R4");
        rd(0, 8'h00, "R4");
        wr(1, 8'h00);
        irq_is(1, "R4");
        rd(0, 8'h80, "R5");
        rd(0, 8'h00, "R5");

        // R6 / R7 D group and its summary
        ev(0, 8'hFF, 0, 0);
        rd(0, 8'h04, "R7");
        rd(0, 8'h04, "R5");
        rd(2, 8'hEF, "R6");
        rd(0, 8'h00, "R7");
        irq_is(0, "R7");
        ev(0, 8'h10, 0, 0);
        rd(2, 8'h00, "R6");
        rd(0, 8'h00, "R7");

        // R8 B1 and B2 summaries
        ev(0, 0, 8'h01, 0);
        rd(0, 8'h02, "R8");
        rd(3, 8'h01, "R8");
        rd(0, 8'h00, "R8");
        ev(0, 0, 0, 8'h80);
        rd(0, 8'h01, "R8");
        rd(4, 8'h80, "R8");
        rd(0, 8'h00, "R8");

        // R9 group mask
        wr(1, 8'h04);
        ev(0, 8'h01, 0, 0);
        irq_is(0, "R9");
        rd(0, 8'h00, "R9");
        rd(2, 8'h01, "R9");
        ev(0, 8'h01, 0, 0);
        wr(1, 8'h00);
        irq_is(1, "R9");
        rd(0, 8'h04, "R9");
        rd(2, 8'h01, "R6");

        // R10 event colliding with a clearing read
        rd_ev(0, 8'h00, "R10", 5'b00001, 0, 0);
        rd(0, 8'h08, "R10");
        rd_ev(2, 8'h00, "R10", 0, 8'h02, 0);
        rd(2, 8'h02, "R10");
        rd_ev(3, 8'h00, "R10", 0, 0, 8'h10);
        rd(0, 8'h02, "R10");
        rd(3, 8'h10, "R10");
        rd(0, 8'h00, "R10");

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit       r, w;
            bit [2:0] a;
            bit [7:0] d;
            r = ($urandom % 3) == 0;
            w = ($urandom % 6) == 0;
            a = 3'($urandom % 8);
            if (w && ($urandom % 2) == 0) a = 3'd1;
            d = 8'($urandom);
            cycle(r, w, a, d,
                  (($urandom % 4) == 0) ? 5'($urandom) : 5'b0,
                  (($urandom % 5) == 0) ? 8'($urandom) : 8'h00,
                  (($urandom % 6) == 0) ? 8'($urandom) : 8'h00,
                  (($urandom % 6) == 0) ? 8'($urandom) : 8'h00);
        end

        summary();
    end

endmodule